// File: doc/BRIEF.md
# Data-Enable Phase Sequencer

This block follows a pixel-clocked video link through three phases, using only a data-enable input. A cycle with data-enable high is video. A cycle with data-enable low that lies within a guard window of `GUARD` cycles on either side of a data-enable edge is a transition. Every other cycle is control. Control words are taken only in the control phase, and pixel words only in the video phase.

The block has to know about a data-enable rise before it happens. To do that, the enable, control and pixel inputs all pass through a delay of `GUARD` register stages, and each cycle is classified with that much lookahead. The control and RGB outputs are held registers. Each one loads only in its own phase and keeps its last value through the other two phases. A 2-bit phase code and one strobe per word group report, for every cycle, what was sampled.

Top module: `phase_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the block forces the phase code to 00, clears both strobes, clears `ctlOut` and `rgbOut` to zero, and clears its input history. Cleared history counts as data-enable low.
- R2: The phase code is 00 for control, 01 for transition and 10 for video, and never 11. The outputs for the input presented at clock edge n appear just after edge n+`GUARD`.
- R3: A cycle with `deIn` high is reported as video (10) and `videoSample` is 1.
- R4: A cycle with `deIn` low is reported as transition (01) if `deIn` is high in any of the next `GUARD` cycles.
- R5: A cycle with `deIn` low is reported as transition (01) if `deIn` was high in any of the previous `GUARD` cycles.
- R6: Every other cycle is control (00). `ctlSample` is 1 and `ctlOut` loads that cycle's control word.
- R7: `ctlOut` keeps its value through every transition and video cycle.
- R8: `rgbOut` loads that cycle's pixel word only in video cycles and keeps its value through every transition and control cycle.
- R9: If the gap between two data-enable pulses is no longer than 2×`GUARD` cycles, the gap is never reported as control.
- R10: `ctlSample` and `videoSample` are never both 1, and each one is 1 exactly when the phase code is control or video respectively.
- R11: A change from transition to control happens only after at least `GUARD` consecutive transition cycles. Video is never entered directly from control, and control is never entered directly from video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| deIn | input | 1 | Data-enable; high marks video cycles |
| ctlIn | input | CTL_W | Control word input |
| rgbIn | input | RGB_W | Pixel word input |
| phase | output | 2 | Phase code of the reported cycle |
| ctlSample | output | 1 | High when the reported cycle sampled control |
| videoSample | output | 1 | High when the reported cycle sampled pixels |
| ctlOut | output | CTL_W | Held control word |
| rgbOut | output | RGB_W | Held pixel word |

## Verification
Every result for the input cycle captured at edge n is due just after edge n+`GUARD`: the phase code, both strobes and both held words. Nothing arrives earlier and nothing arrives later. The bench stores every input it drives. Two nanoseconds after each edge m, it compares all outputs against a model evaluated for input cycle m−`GUARD`. That model looks `GUARD` cycles ahead and `GUARD` cycles behind in the stored enable history and treats cycles before reset as enable low. The directed stretches place enable pulses one cycle long and gaps of one, 2×`GUARD` and 2×`GUARD`+1 cycles. These land the compare on the exact cycle where the guard windows meet or leave a single control cycle.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  typedef enum logic [1:0] {
    PH_CTRL  = 2'b00,
    PH_TRANS = 2'b01,
    PH_VIDEO = 2'b10
  } phase_e;

  // load strobes from the control side to the datapath, valid for the
  // cycle currently at the end of the lookahead delay
  typedef struct packed {
    logic ctlTake;
    logic rgbTake;
  } take_s;

endpackage

// File: rtl/phase_seq_ctrl.sv
module phase_seq_ctrl
  import phase_seq_pkg::*;
#(
  parameter int GUARD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       deIn,
  output take_s      take,
  output logic [1:0] phase,
  output logic       ctlSample,
  output logic       videoSample
);

  localparam int HIST = 2 * GUARD;

  // enable history: deHist[0] is the newest registered value
  logic [HIST-1:0] deHist;
  // window: win[0] live input, win[GUARD] the cycle being classified
  logic [HIST:0]   win;
  logic            aheadHit;
  logic            behindHit;
  logic            nowDe;
  phase_e          curPhase;
  phase_e          phaseQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      deHist <= '0;
    end else begin
      deHist <= {deHist[HIST-2:0], deIn};
    end
  end

  assign win       = {deHist, deIn};
  assign nowDe     = win[GUARD];
  assign aheadHit  = |win[GUARD-1:0];
  assign behindHit = |win[HIST:GUARD+1];

  always_comb begin
    if (nowDe) begin
      curPhase = PH_VIDEO;
    end else if (aheadHit || behindHit) begin
      curPhase = PH_TRANS;
    end else begin
      curPhase = PH_CTRL;
    end
  end

  assign take.ctlTake = (curPhase == PH_CTRL);
  assign take.rgbTake = (curPhase == PH_VIDEO);

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ      <= PH_CTRL;
      ctlSample   <= 1'b0;
      videoSample <= 1'b0;
    end else begin
      phaseQ      <= curPhase;
      ctlSample   <= take.ctlTake;
      videoSample <= take.rgbTake;
    end
  end

  assign phase = phaseQ;

endmodule

// File: rtl/phase_seq_data.sv
module phase_seq_data
  import phase_seq_pkg::*;
#(
  parameter int CTL_W = 3,
  parameter int RGB_W = 24,
  parameter int GUARD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic [RGB_W-1:0] rgbIn,
  input  take_s            take,
  output logic [CTL_W-1:0] ctlOut,
  output logic [RGB_W-1:0] rgbOut
);

  localparam int LAST = GUARD - 1;

  logic [CTL_W-1:0] ctlPipe [GUARD];
  logic [RGB_W-1:0] rgbPipe [GUARD];

  // delay matching the enable history, one stage per guard cycle
  for (genvar s = 0; s < GUARD; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          ctlPipe[s] <= '0;
          rgbPipe[s] <= '0;
        end else begin
          ctlPipe[s] <= ctlIn;
          rgbPipe[s] <= rgbIn;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          ctlPipe[s] <= '0;
          rgbPipe[s] <= '0;
        end else begin
          ctlPipe[s] <= ctlPipe[s-1];
          rgbPipe[s] <= rgbPipe[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlOut <= '0;
      rgbOut <= '0;
    end else begin
      if (take.ctlTake) ctlOut <= ctlPipe[LAST];
      if (take.rgbTake) rgbOut <= rgbPipe[LAST];
    end
  end

endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import phase_seq_pkg::*;
#(
  parameter int CTL_W = 3,
  parameter int RGB_W = 24,
  parameter int GUARD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             deIn,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic [RGB_W-1:0] rgbIn,
  output logic [1:0]       phase,
  output logic             ctlSample,
  output logic             videoSample,
  output logic [CTL_W-1:0] ctlOut,
  output logic [RGB_W-1:0] rgbOut
);

  take_s take;

  phase_seq_ctrl #(.GUARD(GUARD)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .deIn       (deIn),
    .take       (take),
    .phase      (phase),
    .ctlSample  (ctlSample),
    .videoSample(videoSample)
  );

  phase_seq_data #(.CTL_W(CTL_W), .RGB_W(RGB_W), .GUARD(GUARD)) u_data (
    .clk   (clk),
    .rst   (rst),
    .ctlIn (ctlIn),
    .rgbIn (rgbIn),
    .take  (take),
    .ctlOut(ctlOut),
    .rgbOut(rgbOut)
  );

endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk
  import phase_seq_pkg::*;
#(
  parameter int CTL_W = 3,
  parameter int RGB_W = 24,
  parameter int GUARD = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       phase,
  input logic             ctlSample,
  input logic             videoSample,
  input logic [CTL_W-1:0] ctlOut,
  input logic [RGB_W-1:0] rgbOut
);

  localparam int RUN_W = $clog2(GUARD + 2);

  logic [RUN_W-1:0] transRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      transRun <= '0;
    end else if (phase == PH_TRANS) begin
      if (transRun < RUN_W'(GUARD)) transRun <= transRun + 1'b1;
    end else begin
      transRun <= '0;
    end
  end

  p_no_code3_r2: assert property (@(posedge clk) disable iff (rst)
    phase != 2'b11);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctlSample, videoSample}));

  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctlOut) |-> ctlSample);

  p_rgb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rgbOut) |-> videoSample);

  p_guard_len_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CTRL && $past(phase) == PH_TRANS) |-> transRun >= RUN_W'(GUARD));

  p_video_entry_r11: assert property (@(posedge clk) disable iff (rst)
    phase == PH_VIDEO |-> $past(phase) != PH_CTRL);

  p_ctrl_entry_r11: assert property (@(posedge clk) disable iff (rst)
    phase == PH_CTRL |-> $past(phase) != PH_VIDEO);

endmodule

bind phase_seq phase_seq_chk #(.CTL_W(CTL_W), .RGB_W(RGB_W), .GUARD(GUARD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase      (phase),
  .ctlSample  (ctlSample),
  .videoSample(videoSample),
  .ctlOut     (ctlOut),
  .rgbOut     (rgbOut)
);

// File: tb/phase_seq_test.sv
module phase_seq_test;

  localparam int CW = 3;
  localparam int RW = 24;
  localparam int G  = 2;
  localparam int N  = 600;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          deIn = 1'b0;
  logic [CW-1:0] ctlIn = '0;
  logic [RW-1:0] rgbIn = '0;
  logic [1:0]    phase;
  logic          ctlSample;
  logic          videoSample;
  logic [CW-1:0] ctlOut;
  logic [RW-1:0] rgbOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic          deArr  [N];
  logic [CW-1:0] ctlArr [N];
  logic [RW-1:0] rgbArr [N];

  always #5 clk = ~clk;

  phase_seq #(.CTL_W(CW), .RGB_W(RW), .GUARD(G)) uut (
    .clk(clk), .rst(rst), .deIn(deIn), .ctlIn(ctlIn), .rgbIn(rgbIn),
    .phase(phase), .ctlSample(ctlSample), .videoSample(videoSample),
    .ctlOut(ctlOut), .rgbOut(rgbOut)
  );

  function automatic logic getDe(int k);
    if (k < 0 || k >= N) return 1'b0;
    return deArr[k];
  endfunction

  function automatic bit hitAhead(int j);
    for (int k = 1; k <= G; k++) if (getDe(j + k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit hitBehind(int j);
    for (int k = 1; k <= G; k++) if (getDe(j - k)) return 1'b1;
    return 1'b0;
  endfunction

  // 0 control, 1 transition, 2 video
  function automatic int clsAt(int j);
    if (getDe(j)) return 2;
    if (hitAhead(j) || hitBehind(j)) return 1;
    return 0;
  endfunction

  function automatic string phaseTag(int j);
    int c;
    c = clsAt(j);
    if (c == 2) return "R3";
    if (c == 0) return "R6";
    if (hitAhead(j) && hitBehind(j)) return "R9";
    if (hitAhead(j)) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedVal;
    int idx;
    logic [CW-1:0] expCtl;
    logic [RW-1:0] expRgb;
    int run;
    logic [1:0] prevPhase;

    seedVal = $urandom(32'd2024);
    for (int i = 0; i < N; i++) begin
      deArr[i]  = 1'b0;
      ctlArr[i] = CW'($urandom);
      rgbArr[i] = RW'($urandom);
    end
    // directed: lone pulse, gap 1, gap 2G, gap 2G+1
    deArr[10] = 1'b1;
    for (int i = 21; i <= 24; i++) deArr[i] = 1'b1;
    for (int i = 26; i <= 27; i++) deArr[i] = 1'b1;
    for (int i = 32; i <= 33; i++) deArr[i] = 1'b1;
    for (int i = 39; i <= 41; i++) deArr[i] = 1'b1;
    // random bursts
    idx = 60;
    while (idx < N - 10) begin
      int hi;
      int lo;
      hi = 1 + int'($urandom % 8);
      lo = 1 + int'($urandom % 9);
      for (int k = 0; k < hi && idx < N - 10; k++) begin
        deArr[idx] = 1'b1;
        idx++;
      end
      idx += lo;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "phase", 32'(phase), 32'd0);
    chk("R1", "ctlSample", 32'(ctlSample), 32'd0);
    chk("R1", "videoSample", 32'(videoSample), 32'd0);
    chk("R1", "ctlOut", 32'(ctlOut), 32'd0);
    chk("R1", "rgbOut", 32'(rgbOut), 32'd0);

    expCtl = '0;
    expRgb = '0;
    run = 0;
    prevPhase = 2'b00;
    rst = 1'b0;
    for (int m = 0; m < N; m++) begin
      int j;
      int c;
      deIn  = deArr[m];
      ctlIn = ctlArr[m];
      rgbIn = rgbArr[m];
      @(posedge clk);
      #2;
      j = m - G;
      c = clsAt(j);
      if (c == 0) expCtl = (j < 0) ? '0 : ctlArr[j];
      if (c == 2) expRgb = rgbArr[j];
      chk("R2", "phase code legal", 32'(phase == 2'b11), 32'd0);
      chk(phaseTag(j), "phase", 32'(phase), 32'(c));
      chk("R10", "ctlSample", 32'(ctlSample), 32'(c == 0));
      chk("R10", "videoSample", 32'(videoSample), 32'(c == 2));
      chk((c == 0) ? "R6" : "R7", "ctlOut", 32'(ctlOut), 32'(expCtl));
      chk("R8", "rgbOut", 32'(rgbOut), 32'(expRgb));
      // R11: observed transition run before control
      if (phase == 2'b00 && prevPhase == 2'b01)
        chk("R11", "transition run", 32'(run >= G), 32'd1);
      if (phase == 2'b01) run++;
      else run = 0;
      prevPhase = phase;
      @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule